// File: doc/BRIEF.md
# Inbound Memory Window Address Translator

This block maps three system-bus memory windows onto a 32-bit PCI memory space. Each window has a fixed byte size and a translation word that software programs through a small 32-bit register port. A lookup request names a window and a byte offset inside it. The block returns the PCI address that this offset reaches, and a flag that says whether the offset lies inside the window.

A strap input picks one of two board flavours. Each flavour has its own window sizes and its own reading of the translation word. In the nibble flavour, the low four bits of the word become PCI address bits 31:28. In the masked flavour, the word itself is the base, with every bit below the window size cleared.

Lookups travel as a stream. A request is taken on a clock edge where `lk_valid` and `lk_ready` are both high. Its result appears on the `rs_*` outputs at that same edge and stays there until a cycle ends with `rs_ready` high. `lk_ready` is high when no result is pending, or when the pending result is being taken in that cycle. Under back-pressure, neither the held result nor the request is lost.

Top module: `mem_window_xlate`

## Requirements
- R1: The translation words sit at register offsets 0x010, 0x014 and 0x018, for windows 0, 1 and 2. All three reset to zero, and a word-sized read returns the last value written.
- R2: A request whose `reg_size` is not 2'b10 (4 bytes) returns `rsp_err`=1 and read data 0. A write of this kind leaves the register unchanged.
- R3: A request to any offset other than the three decoded ones, including unaligned offsets, returns `rsp_err`=1 and read data 0, and changes no register.
- R4: With `variant_sel`=0, the base for a window is the translation word's bits 3:0 placed at PCI address bits 31:28. All other bits of the word have no effect.
- R5: With `variant_sel`=1, the base is the translation word with every bit below the window size cleared.
- R6: Window sizes are 0x0C000000, 0x10000000 and 0x10000000 when `variant_sel`=0, and 0x01000000, 0x04000000 and 0x08000000 when `variant_sel`=1. `rs_hit` is 1 exactly when the offset is below the window's size. A window index of 3 always gives `rs_hit`=0 and uses base 0.
- R7: `rs_addr` equals base plus offset, modulo 2^32. This holds even when `rs_hit` is 0.
- R8: A new translation word is used by a lookup accepted on the clock edge after the write's edge.
- R9: `lk_ready` = !`rs_valid` || `rs_ready`. While `rs_valid` is high and `rs_ready` is low, `rs_addr` and `rs_hit` hold steady.
- R10: Every register request receives exactly one response, with `rsp_valid` high for one cycle on the edge after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| variant_sel | input | 1 | Board flavour strap (0 nibble, 1 masked) |
| reg_req | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_size | input | 2 | Access size code, 2'b10 = 4 bytes |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Register response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Bad offset or size |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready |
| lk_win | input | 2 | Window index |
| lk_off | input | 32 | Byte offset within the window |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result ready |
| rs_addr | output | 32 | Translated PCI address |
| rs_hit | output | 1 | Offset lies inside the window |

## Verification
Some rules are checked by the assertions on every cycle. These are the stream handshake, with results held under back-pressure and ready whenever the output is empty. They also cover the one-cycle response timing, error flagging for wrong sizes and low offsets, and a forced miss for window index 3. The translation arithmetic under each flavour, the per-window sizes, the masking boundaries, address wrap-around, write-to-use timing and register protection after rejected writes show up only in the bench's scenarios.

// File: rtl/mwx_pkg.sv
package mwx_pkg;
  localparam int NUM_WIN   = 3;
  localparam int WIN_W     = 2;
  localparam int PCI_AW    = 32;
  localparam int REG_AW    = 12;
  localparam int NIB_W     = 4;
  localparam logic [REG_AW-1:0] XLAT_BASE = 12'h010;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef logic [PCI_AW-1:0] word_t;

  function automatic word_t win_size(input logic variant, input int idx);
    word_t s;
    if (!variant) begin
      case (idx)
        0:       s = 32'h0C00_0000;
        default: s = 32'h1000_0000;
      endcase
    end else begin
      case (idx)
        0:       s = 32'h0100_0000;
        1:       s = 32'h0400_0000;
        default: s = 32'h0800_0000;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/mwx_regfile.sv
module mwx_regfile
  import mwx_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic                      wr,
  input  logic [1:0]                size,
  input  logic [REG_AW-1:0]         addr,
  input  word_t                     wdata,
  output logic                      rsp_valid,
  output word_t                     rsp_rdata,
  output logic                      rsp_err,
  output logic [NUM_WIN-1:0][PCI_AW-1:0] xlat
);
  localparam int IDX_W = REG_AW - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WIN);

  logic [REG_AW-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic              hit_dec;
  logic              ok;
  word_t             rd_mux;

  assign rel     = addr - XLAT_BASE;
  assign idx     = rel[REG_AW-1:2];
  assign hit_dec = (addr >= XLAT_BASE) && (rel[1:0] == 2'b00) && (idx < LAST_IDX);
  assign ok      = hit_dec && (size == SIZE_WORD);

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (idx == IDX_W'(i)) rd_mux = xlat[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlat      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req;
      rsp_err   <= req && !ok;
      rsp_rdata <= (req && ok && !wr) ? rd_mux : '0;
      if (req && ok && wr)
        for (int i = 0; i < NUM_WIN; i++)
          if (idx == IDX_W'(i)) xlat[i] <= wdata;
    end
  end
endmodule

// File: rtl/mwx_xlate.sv
module mwx_xlate
  import mwx_pkg::*;
(
  input  logic                           variant,
  input  logic [NUM_WIN-1:0][PCI_AW-1:0] xlat,
  input  logic [WIN_W-1:0]               win,
  input  word_t                          off,
  output word_t                          addr,
  output logic                           hit
);
  word_t bases [NUM_WIN];
  word_t sizes [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    word_t nib_base, mask_base;
    assign sizes[g]  = win_size(variant, g);
    assign nib_base  = {xlat[g][NIB_W-1:0], {(PCI_AW-NIB_W){1'b0}}};
    assign mask_base = xlat[g] & ~(sizes[g] - 32'd1);
    assign bases[g]  = variant ? mask_base : nib_base;
  end

  word_t sel_base, sel_size;
  logic  sel_ok;
  always_comb begin
    sel_base = '0;
    sel_size = '0;
    sel_ok   = 1'b0;
    for (int i = 0; i < NUM_WIN; i++)
      if (win == WIN_W'(i)) begin
        sel_base = bases[i];
        sel_size = sizes[i];
        sel_ok   = 1'b1;
      end
  end

  assign addr = sel_base + off;
  assign hit  = sel_ok && (off < sel_size);
endmodule

// File: rtl/mwx_out_stage.sv
module mwx_out_stage #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/mem_window_xlate.sv
module mem_window_xlate
  import mwx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              variant_sel,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [1:0]        reg_size,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [WIN_W-1:0]  lk_win,
  input  logic [31:0]       lk_off,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [31:0]       rs_addr,
  output logic              rs_hit
);
  logic [NUM_WIN-1:0][PCI_AW-1:0] xlat;
  word_t xl_addr;
  logic  xl_hit;

  mwx_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .req(reg_req), .wr(reg_wr), .size(reg_size),
    .addr(reg_addr), .wdata(reg_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .xlat(xlat)
  );

  mwx_xlate u_xlate (
    .variant(variant_sel), .xlat(xlat), .win(lk_win), .off(lk_off),
    .addr(xl_addr), .hit(xl_hit)
  );

  mwx_out_stage #(.W(PCI_AW + 1)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(lk_valid), .in_ready(lk_ready),
    .in_data({xl_hit, xl_addr}), .out_valid(rs_valid), .out_ready(rs_ready),
    .out_data({rs_hit, rs_addr})
  );
endmodule

// File: rtl/mwx_checker.sv
module mwx_checker
  import mwx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic [1:0]        reg_size,
  input logic [REG_AW-1:0] reg_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [WIN_W-1:0]  lk_win,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic [31:0]       rs_addr,
  input logic              rs_hit
);
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_addr) && $stable(rs_hit)); // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> lk_ready); // R9
  AST_BAD_WINDOW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && (lk_win == 2'd3) |=> rs_valid && !rs_hit); // R6
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> rsp_valid); // R10
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_req |=> !rsp_valid); // R10
  AST_SIZE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && (reg_size != SIZE_WORD) |=> rsp_err); // R2
  AST_LOW_OFFSET_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && (reg_addr < XLAT_BASE) |=> rsp_err); // R3
endmodule

bind mem_window_xlate mwx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_size(reg_size),
  .reg_addr(reg_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_win(lk_win),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_addr(rs_addr), .rs_hit(rs_hit)
);

// File: tb/mem_window_xlate_test.sv
module mem_window_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic        v;
    logic [1:0]  w;
    logic [31:0] r;
    logic [31:0] o;
    logic [31:0] a;
    logic        h;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 32'h0000_0005, 32'h0000_0100, 32'h5000_0100, 1'b1},
    '{1'b0, 2'd0, 32'hFFFF_FFF3, 32'h0BFF_FFFF, 32'h3BFF_FFFF, 1'b1},
    '{1'b0, 2'd0, 32'h0000_0001, 32'h0C00_0000, 32'h1C00_0000, 1'b0},
    '{1'b0, 2'd1, 32'h0000_000A, 32'h0FFF_FFFF, 32'hAFFF_FFFF, 1'b1},
    '{1'b0, 2'd2, 32'h0000_000F, 32'h1000_0000, 32'h0000_0000, 1'b0},
    '{1'b1, 2'd0, 32'h1234_5678, 32'h00AB_CDEF, 32'h12AB_CDEF, 1'b1},
    '{1'b1, 2'd1, 32'h8765_4321, 32'h03FF_FFFF, 32'h87FF_FFFF, 1'b1},
    '{1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0800_0000, 32'h0000_0000, 1'b0},
    '{1'b1, 2'd0, 32'h0000_0000, 32'h0100_0000, 32'h0100_0000, 1'b0},
    '{1'b1, 2'd3, 32'hDEAD_BEEF, 32'h0000_0123, 32'h0000_0123, 1'b0}
  };

  logic clk = 0, rst_n = 0, variant_sel = 0;
  logic reg_req = 0, reg_wr = 0;
  logic [1:0] reg_size = 2'b10;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, rsp_rdata, lk_off = '0, rs_addr;
  logic rsp_valid, rsp_err, lk_valid = 0, lk_ready, rs_valid, rs_ready = 1, rs_hit;
  logic [1:0] lk_win = '0;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_window_xlate uut (
    .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel), .reg_req(reg_req),
    .reg_wr(reg_wr), .reg_size(reg_size), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_win(lk_win), .lk_off(lk_off), .rs_valid(rs_valid),
    .rs_ready(rs_ready), .rs_addr(rs_addr), .rs_hit(rs_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one register access; response sampled on the negedge after the request edge
  task automatic reg_op(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                        input logic [31:0] d, output logic [31:0] rd, output logic err);
    reg_req = 1; reg_wr = wr; reg_size = sz; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_req = 0;
    check("R10 rsp_valid", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata; err = rsp_err;
  endtask

  task automatic lookup(input logic [1:0] w, input logic [31:0] o);
    lk_valid = 1; lk_win = w; lk_off = o;
    @(posedge clk); @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    logic err;
    repeat (3) @(negedge clk);
    check("R9 rs_valid after reset", 32'(rs_valid), 32'd0);
    check("R9 lk_ready after reset", 32'(lk_ready), 32'd1);
    rst_n = 1;
    @(negedge clk);
    check("R10 no response when idle", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < 3; i++) begin
      reg_op(0, 2'b10, 12'h010 + 12'(4*i), 0, rd, err);
      check("R1 reset value", rd, 32'd0);
      check("R1 no error", 32'(err), 32'd0);
    end

    // vector table: each write followed at once by the lookup (R8)
    for (int i = 0; i < NV; i++) begin
      variant_sel = VECS[i].v;
      if (VECS[i].w != 2'd3) begin
        reg_op(1, 2'b10, 12'h010 + 12'(4*VECS[i].w), VECS[i].r, rd, err);
        check("R1 write accepted", 32'(err), 32'd0);
      end
      lookup(VECS[i].w, VECS[i].o);
      check("R8 result valid", 32'(rs_valid), 32'd1);
      check(VECS[i].v ? "R5 R7 addr" : "R4 R7 addr", rs_addr, VECS[i].a);
      check("R6 hit", 32'(rs_hit), 32'(VECS[i].h));
    end

    // R1 readback
    reg_op(1, 2'b10, 12'h014, 32'hCAFE_F00D, rd, err);
    reg_op(0, 2'b10, 12'h014, 0, rd, err);
    check("R1 readback", rd, 32'hCAFE_F00D);
    // R2 wrong size write ignored
    reg_op(1, 2'b01, 12'h014, 32'h1111_1111, rd, err);
    check("R2 size error", 32'(err), 32'd1);
    reg_op(0, 2'b00, 12'h014, 0, rd, err);
    check("R2 size error read", 32'(err), 32'd1);
    check("R2 read data zero", rd, 32'd0);
    reg_op(0, 2'b10, 12'h014, 0, rd, err);
    check("R2 register kept", rd, 32'hCAFE_F00D);
    // R3 undecoded offsets
    reg_op(1, 2'b10, 12'h01C, 32'h2222_2222, rd, err);
    check("R3 past last", 32'(err), 32'd1);
    reg_op(1, 2'b10, 12'h012, 32'h3333_3333, rd, err);
    check("R3 unaligned", 32'(err), 32'd1);
    reg_op(0, 2'b10, 12'h000, 0, rd, err);
    check("R3 below base", 32'(err), 32'd1);
    check("R3 read zero", rd, 32'd0);
    for (int i = 0; i < 3; i++) begin
      reg_op(0, 2'b10, 12'h010 + 12'(4*i), 0, rd, err);
      check("R3 no register changed", 32'(rd == 32'h2222_2222 || rd == 32'h3333_3333), 32'd0);
    end

    // R9 back-pressure: window 1 in nibble flavour holds 0xCAFEF00D -> base 0xD0000000
    variant_sel = 0;
    rs_ready = 0;
    lookup(2'd1, 32'h0000_0040);
    check("R9 ready low when full", 32'(lk_ready), 32'd0);
    lk_valid = 1; lk_win = 2'd1; lk_off = 32'h0000_0080;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    check("R9 held addr", rs_addr, 32'hD000_0040);
    check("R9 held valid", 32'(rs_valid), 32'd1);
    rs_ready = 1;
    @(posedge clk); @(negedge clk);
    lk_valid = 0;
    check("R9 next result", rs_addr, 32'hD000_0080);
    @(posedge clk); @(negedge clk);
    check("R9 drained", 32'(rs_valid), 32'd0);
    summary();
  end
endmodule